// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block runs indirect-address management transactions toward an external 10G PHY over a two-wire serial management bus. It produces the management clock (MDC) from the system clock through a programmable divider. It drives the bidirectional data line (MDIO) through separate output, output-enable and input pins, and it shifts command fields out and read data in.

A client presents one request: read or write, a 5-bit port address, a 5-bit device address, a 16-bit register address and 16-bit write data. The master turns every request into two frames sent back to back. The first frame loads the register address. The second frame writes the data or reads it back. When the second frame finishes, the master raises a one-cycle completion pulse. After a read, the captured 16-bit word is held on the read-data output.

Between requests, both line drivers are released and the master reports that it can accept work. The master itself drives the two turnaround bits of every frame, reads included. It lets go of MDIO only for the sixteen read-data bit times.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset and whenever no request is in progress, `ready` is 1 and `mdc_oe` and `mdio_oe` are 0. A request is taken on a clock edge where `req_valid` and `ready` are both 1. A `req_valid` pulse while `ready` is 0 changes neither the frames in flight nor what follows them.
- R2: MDC has a period of 2*HALF_DIV system clocks, and each half lasts HALF_DIV clocks. The first low half starts in the cycle right after acceptance, and MDC is low whenever `mdc_oe` is 0.
- R3: Every frame opens with 32 bit times of MDIO driven 1, then two bit times driven 0.
- R4: The 2-bit opcode goes out MSB first. It is 00 in the first (address) frame, 01 in the second frame of a write, and 11 in the second frame of a read.
- R5: After the opcode come the 5-bit port address and then the 5-bit device address, each sent MSB first.
- R6: The two turnaround bit times are driven as 1 then 0 by the master in both frames, with `mdio_oe` at 1, for reads as well as writes.
- R7: The last 16 bit times, sent MSB first, carry the register address in the first frame and the write data in the second frame of a write.
- R8: The values on `mdio_o` and `mdio_oe` change only when MDC falls. They do not change while MDC is high.
- R9: In the second frame of a read, `mdio_oe` is 0 for the last 16 bit times. `mdio_i` is sampled in the last system clock of each MDC low half, and those 16 bits, MSB first, become `rd_data`.
- R10: `done` is high for exactly one clock, in the first cycle after the second frame ends, and `ready` is 1 in that same cycle. `rd_data` keeps its value until a later read frame samples new bits, so a write request leaves it unchanged.
- R11: The two frames run with no gap between them. One request takes 128 MDC periods, and `done` rises 256*HALF_DIV clocks after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_port | input | 5 | Port address of the PHY |
| req_dev | input | 5 | Device address inside the PHY |
| req_regad | input | 16 | Register address |
| req_wdata | input | 16 | Data for a write request |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse when a request completes |
| rd_data | output | 16 | Last word read from the PHY |
| mdc_o | output | 1 | Management clock value |
| mdc_oe | output | 1 | Management clock output enable |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
A wrong bit counter or frame-select state shows up at the MDC rising edges of the affected frame. A misplaced field, a missing turnaround drive or a wrongly timed release is visible within one bit time, which is 2*HALF_DIV clocks. A divider fault breaks the spacing between MDC rising edges right away. It also moves the completion pulse away from 256*HALF_DIV clocks. A wrong read-sampling point or bit order only appears in `rd_data` at the completion pulse, up to 128 MDC periods after acceptance.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Two-bit operation codes carried in every frame.
    typedef enum logic [1:0] {
        OPC_ADDR   = 2'd0,
        OPC_WRITE  = 2'd1,
        OPC_RD_INC = 2'd2,
        OPC_READ   = 2'd3
    } mdio_opc_e;

    // Fixed line patterns inside a frame.
    localparam logic [1:0] SOF_BITS = 2'b00;
    localparam logic [1:0] TA_BITS  = 2'b10;

endpackage

// File: rtl/mdio_clk_phase.sv
// Half-period counter: produces the MDC level and strobes marking the
// last system clock of each low half (rise_stb) and high half (fall_stb).
module mdio_clk_phase #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc_hi,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hi;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (!run) begin
            ph_d = '0;
        end else if (ph_q.cnt == LAST) begin
            ph_d.cnt = '0;
            ph_d.hi  = ~ph_q.hi;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign mdc_hi   = ph_q.hi;
    assign rise_stb = run && (ph_q.cnt == LAST) && !ph_q.hi;
    assign fall_stb = run && (ph_q.cnt == LAST) &&  ph_q.hi;

endmodule

// File: rtl/mdio_frame_seq.sv
// Tracks the bit position inside a frame and which of the two frames of a
// request is on the line; advances on each MDC falling strobe.
module mdio_frame_seq #(
    parameter int FRAME_BITS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          start_read,
    input  logic                          fall_stb,
    output logic                          active,
    output logic                          second,
    output logic                          is_read,
    output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    output logic                          done
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    typedef struct packed {
        logic          active;
        logic          second;
        logic          is_read;
        logic          done;
        logic [BW-1:0] bit_idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (!sq_q.active) begin
            if (start) begin
                sq_d.active  = 1'b1;
                sq_d.second  = 1'b0;
                sq_d.is_read = start_read;
                sq_d.bit_idx = '0;
            end
        end else if (fall_stb) begin
            if (sq_q.bit_idx == LAST_BIT) begin
                sq_d.bit_idx = '0;
                if (!sq_q.second) begin
                    sq_d.second = 1'b1;
                end else begin
                    sq_d.active = 1'b0;
                    sq_d.second = 1'b0;
                    sq_d.done   = 1'b1;
                end
            end else begin
                sq_d.bit_idx = sq_q.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign active  = sq_q.active;
    assign second  = sq_q.second;
    assign is_read = sq_q.is_read;
    assign bit_idx = sq_q.bit_idx;
    assign done    = sq_q.done;

endmodule

// File: rtl/mdio_rd_capture.sv
// Shift register collecting read data MSB first.
module mdio_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic [DATA_W-1:0] sr;
    } cap_t;

    cap_t cp_d, cp_q;

    always_comb begin
        cp_d = cp_q;
        if (sample_en) begin
            cp_d.sr = {cp_q.sr[DATA_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cp_q <= '0;
        else        cp_q <= cp_d;
    end

    assign data = cp_q.sr;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PRE_BITS = 32,
    parameter int PORT_W   = 5,
    parameter int DEV_W    = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [PORT_W-1:0] req_port,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [DATA_W-1:0] req_regad,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc_o,
    output logic              mdc_oe,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PORT_W + DEV_W + 2 + DATA_W;
    localparam int DATA_START = FRAME_BITS - DATA_W;
    localparam int BW         = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t rq_d, rq_q;

    logic          fire;
    logic          act, second, is_read, seq_done;
    logic [BW-1:0] bit_idx;
    logic          mdc_hi, rise_stb, fall_stb;
    logic          in_rd_data;
    logic [BW-1:0] msb_idx;
    mdio_opc_e     opc;
    logic [DATA_W-1:0]     payload;
    logic [FRAME_BITS-1:0] frame_w;

    assign fire = req_valid && !act;

    // Request latch: fields are taken only on acceptance.
    always_comb begin
        rq_d = rq_q;
        if (fire) begin
            rq_d.port  = req_port;
            rq_d.dev   = req_dev;
            rq_d.regad = req_regad;
            rq_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    mdio_clk_phase #(
        .HALF_DIV (HALF_DIV)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (act),
        .mdc_hi   (mdc_hi),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fire),
        .start_read (req_read),
        .fall_stb   (fall_stb),
        .active     (act),
        .second     (second),
        .is_read    (is_read),
        .bit_idx    (bit_idx),
        .done       (seq_done)
    );

    // Frame assembly: the whole frame as one word, indexed by bit position.
    always_comb begin
        if (!second)      opc = OPC_ADDR;
        else if (is_read) opc = OPC_READ;
        else              opc = OPC_WRITE;
        payload = (second && !is_read) ? rq_q.wdata : rq_q.regad;
        frame_w = {{PRE_BITS{1'b1}}, SOF_BITS, opc, rq_q.port, rq_q.dev,
                   TA_BITS, payload};
    end

    assign msb_idx    = BW'(FRAME_BITS - 1) - bit_idx;
    assign in_rd_data = second && is_read && (bit_idx >= BW'(DATA_START));

    mdio_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (rise_stb && in_rd_data),
        .bit_in    (mdio_i),
        .data      (rd_data)
    );

    assign ready   = !act;
    assign done    = seq_done;
    assign mdc_oe  = act;
    assign mdc_o   = act && mdc_hi;
    assign mdio_oe = act && !in_rd_data;
    assign mdio_o  = mdio_oe && frame_w[msb_idx];

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic              mdc_o,
    input logic              mdc_oe,
    input logic              mdio_o,
    input logic              mdio_oe
);
    // R1: idle means both drivers released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mdc_oe && !mdio_oe));

    // R2: MDC stays low while its driver is off
    a_r2_mdc_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_oe |-> !mdc_o);

    // R3: acceptance starts a low MDC half with preamble driven high
    a_r3_start_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> (!ready && mdc_oe && !mdc_o && mdio_oe && mdio_o));

    // R8: no MDIO change while MDC stays high
    a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R10: single-cycle completion pulse, seen together with ready
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R10: read data frozen while idle
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ready) && ready) |-> $stable(rd_data));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .rd_data   (rd_data),
    .mdc_o     (mdc_o),
    .mdc_oe    (mdc_oe),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
    localparam int HALF  = 3;
    localparam int NCYC  = 2 * 64 * 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_port = '0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_regad = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, done, mdc_o, mdc_oe, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    mdio_mgmt_master #(.HALF_DIV(HALF)) u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_port(req_port), .req_dev(req_dev), .req_regad(req_regad),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rd_data(rd_data),
        .mdc_o(mdc_o), .mdc_oe(mdc_oe), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY-side monitor and responder
    logic [15:0] phy_rd = '0;
    logic        cap_o  [128];
    logic        cap_oe [128];
    int rise_cnt = 0, per_err = 0, hold_err = 0, last_rise = -1, cyc = 0;
    logic prev_mdc = 0, prev_o = 0, prev_oe = 0, prev_mdc_oe = 0;

    always @(negedge clk) begin
        cyc++;
        if (mdc_oe && !prev_mdc_oe) begin
            rise_cnt = 0; per_err = 0; hold_err = 0; last_rise = -1;
        end
        if (mdc_o && !prev_mdc) begin
            if (rise_cnt < 128) begin
                cap_o[rise_cnt]  = mdio_o;
                cap_oe[rise_cnt] = mdio_oe;
            end
            if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) per_err++;
            last_rise = cyc;
            rise_cnt++;
        end
        if (mdc_o && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) hold_err++;
        mdio_i = (rise_cnt >= 112 && rise_cnt < 128) ? phy_rd[127 - rise_cnt] : 1'b1;
        prev_mdc = mdc_o; prev_o = mdio_o; prev_oe = mdio_oe; prev_mdc_oe = mdc_oe;
    end

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                              input logic [4:0] d, input logic [15:0] v);
        return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, v};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [15:0] last_read = '0;

    task automatic do_req(input logic rd, input logic [4:0] p, input logic [4:0] d,
                          input logic [15:0] ra, input logic [15:0] wd,
                          input logic [15:0] prd, input logic poke);
        int k;
        logic [63:0] a1, a2, o1, o2, e1, e2, eoe2;
        logic [15:0] rd_at_done;
        @(negedge clk);
        while (!ready) @(negedge clk);
        phy_rd = prd;
        req_read = rd; req_port = p; req_dev = d; req_regad = ra; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy and MDC low after accept", {62'd0, mdc_oe, mdc_o}, 64'd2);
        k = 0;
        while (!done && k < NCYC + 50) begin
            @(negedge clk);
            k++;
            if (poke && k == 100) begin
                req_valid = 1'b1; req_read = ~rd; req_port = ~p; req_dev = ~d;
                req_regad = ~ra; req_wdata = ~wd;
            end
            if (poke && k == 101) req_valid = 1'b0;
        end
        chk("R11 done latency", 64'(k), 64'(NCYC));
        chk("R10 ready with done", {63'd0, ready}, 64'd1);
        chk("R11 MDC periods", 64'(rise_cnt), 64'd128);
        chk("R2 MDC period", 64'(per_err), 64'd0);
        chk("R8 no change while MDC high", 64'(hold_err), 64'd0);
        for (int i = 0; i < 64; i++) begin
            a1[63-i] = cap_o[i];      a2[63-i] = cap_o[64+i];
            o1[63-i] = cap_oe[i];     o2[63-i] = cap_oe[64+i];
        end
        e1 = exp_frame(2'b00, p, d, ra);
        e2 = exp_frame(rd ? 2'b11 : 2'b01, p, d, wd);
        eoe2 = rd ? {48'hFFFF_FFFF_FFFF, 16'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
        chk("R3 preamble and start", {a1[63:30], a2[63:30]}, {e1[63:30], e2[63:30]});
        chk("R4 opcodes", {a1[29:28], a2[29:28]}, {e1[29:28], e2[29:28]});
        chk("R5 port and device", {a1[27:18], a2[27:18]}, {e1[27:18], e2[27:18]});
        chk("R6 turnaround driven", {a1[17:16], a2[17:16], o1[17:16], o2[17:16]},
            {e1[17:16], e2[17:16], 4'b1111});
        chk("R7 address field", a1[15:0], e1[15:0]);
        if (!rd) chk("R7 write data field", a2[15:0], e2[15:0]);
        chk("R9 output enable pattern", {o1, o2}, {64'hFFFF_FFFF_FFFF_FFFF, eoe2});
        if (rd) last_read = prd;
        chk("R9 R10 read data", rd_data, last_read);
        rd_at_done = rd_data;
        @(negedge clk);
        chk("R10 done single cycle", {63'd0, done}, 64'd0);
        repeat (4) @(negedge clk);
        chk("R1 idle after request", {rd_data, 1'(mdc_oe), 1'(mdio_oe), 1'(ready), 5'(rise_cnt >> 3)},
            {rd_at_done, 3'b001, 5'd16});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired (R1..R11 incomplete)");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", {rd_data, ready, mdc_oe, mdio_oe, done, mdc_o},
            {16'h0, 5'b10000});
        do_req(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0);
        do_req(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 16'h0, 1'b0);
        do_req(1'b1, 5'h15, 5'h0A, 16'hC000, 16'h1234, 16'h8001, 1'b0);
        do_req(1'b0, 5'h03, 5'h04, 16'h5A5A, 16'hA5A5, 16'h0, 1'b1);   // R1 busy poke, R10 hold
        do_req(1'b1, 5'h01, 5'h01, 16'h0002, 16'h0000, 16'hFFFF, 1'b1);
        do_req(1'b1, 5'h10, 5'h03, 16'hD7FD, 16'h0000, 16'h0000, 1'b0);
        for (int n = 0; n < 30; n++) begin
            do_req(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                   16'($urandom), 16'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule